// File: doc/BRIEF.md
# Scaled Index Shift-and-Add Unit

This block is a single-cycle integer execution unit that forms a scaled address: it multiplies an index operand by a small power of two and adds a base operand. A 2-bit scale field selects the multiplier. The shift distance is always the scale field plus one, so the index is multiplied by 2, 4, 8 or 16 and never passed through unscaled.

Two variants are selected per operation. The full variant scales the whole 64-bit index. The word variant keeps only the low 32 bits of the index, zero-extended, so that a 64-bit base can be offset by a 32-bit unsigned element number. Everything is unsigned. The sum wraps modulo 2^64 and no carry or overflow indication is produced.

An issuing stage presents the operands together with a valid strobe. The result appears in an output register one clock later, flagged by its own valid bit. Decode, register-file access and flags belong to the surrounding pipeline.

Top module: `sas_unit`

## Requirements
- R1: The shift distance is the scale field plus one: scale 0, 1, 2 and 3 multiply the index by 2, 4, 8 and 16 respectively.
- R2: With `word_mode` = 0 (full variant), the result is `(index_in << (scale+1)) + base_in` truncated to 64 bits; index bits shifted past bit 63 are dropped before the addition.
- R3: With `word_mode` = 1 (word variant), only `index_in[31:0]` is used, zero-extended; the value of `index_in[63:32]` has no effect on the result.
- R4: In the word variant no index bit is lost: the scaled index equals the 32-bit value times 2^(scale+1) exactly, occupying at most bits 35:0.
- R5: The addition wraps modulo 2^64; a carry out of bit 63 is discarded and there is no carry or overflow output.
- R6: `res_vld` is high in the cycle after a cycle with `issue_vld` high and low otherwise; `res_out` carries that operation's result in the same cycle.
- R7: A synchronous active-high `rst` clears `res_vld` and `res_out` to zero.
- R8: While `issue_vld` is low, the operand inputs have no effect: `res_out` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Operation valid this cycle |
| word_mode | input | 1 | 0 = full 64-bit index, 1 = low 32-bit index zero-extended |
| scale | input | 2 | Scale field; shift distance is scale+1 |
| base_in | input | 64 | Base operand |
| index_in | input | 64 | Index operand |
| res_vld | output | 1 | Result valid, one cycle after issue |
| res_out | output | 64 | Registered result |

## Verification
The bench sweeps every scale value in both variants. A design that shifted by the raw scale field would return base plus the unscaled index for scale 0 and be off by a factor of two everywhere else. In the word variant it supplies indices with nonzero upper halves, which a design that failed to mask them would add in. It also supplies all-ones indices, which a design that truncated the scaled word to 32 bits would clip. An all-ones base together with a nonzero index makes the sum wrap, which exposes any design that saturates or keeps a 65th bit. Idle cycles with changing operands catch a register that loads when no operation was issued, and back-to-back issues catch a valid flag that is stretched or lost.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic {
    SAS_FULL = 1'b0,
    SAS_WORD = 1'b1
  } sas_mode_e;

  localparam int SAS_DATA_W_DEF  = 64;
  localparam int SAS_WORD_W_DEF  = 32;
  localparam int SAS_SCALE_W_DEF = 2;
endpackage

// File: rtl/sas_idx_prep.sv
module sas_idx_prep
  import sas_pkg::*;
#(
  parameter int DATA_W = SAS_DATA_W_DEF,
  parameter int WORD_W = SAS_WORD_W_DEF
) (
  input  logic              word_mode,
  input  logic [DATA_W-1:0] index_in,
  output logic [DATA_W-1:0] prep_idx
);
  localparam int PAD_W = DATA_W - WORD_W;

  function automatic logic [DATA_W-1:0] low_zext(input logic [DATA_W-1:0] v);
    return {{PAD_W{1'b0}}, v[WORD_W-1:0]};
  endfunction

  always_comb begin
    if (sas_mode_e'(word_mode) == SAS_WORD) prep_idx = low_zext(index_in);
    else                                    prep_idx = index_in;
  end
endmodule

// File: rtl/sas_scaler.sv
module sas_scaler
  import sas_pkg::*;
#(
  parameter int DATA_W  = SAS_DATA_W_DEF,
  parameter int SCALE_W = SAS_SCALE_W_DEF
) (
  input  logic [SCALE_W-1:0] scale,
  input  logic [DATA_W-1:0]  value_in,
  output logic [SCALE_W:0]   shamt,
  output logic [DATA_W-1:0]  value_out
);
  localparam int NSEL    = 1 << SCALE_W;
  localparam int SHAMT_W = SCALE_W + 1;

  logic [DATA_W-1:0] cand [NSEL];

  // one fixed-distance candidate per scale code, distance = code + 1
  for (genvar s = 0; s < NSEL; s++) begin : g_cand
    assign cand[s] = value_in << (s + 1);
  end

  function automatic logic [SHAMT_W-1:0] dist_of(input logic [SCALE_W-1:0] sc);
    return {1'b0, sc} + SHAMT_W'(1);
  endfunction

  assign shamt     = dist_of(scale);
  assign value_out = cand[scale];
endmodule

// File: rtl/sas_adder.sv
module sas_adder
  import sas_pkg::*;
#(
  parameter int DATA_W = SAS_DATA_W_DEF
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [DATA_W:0] full;
    full = {1'b0, x} + {1'b0, y};
    return full[DATA_W-1:0];
  endfunction

  assign sum = add_wrap(a, b);
endmodule

// File: rtl/sas_unit.sv
module sas_unit
  import sas_pkg::*;
#(
  parameter int DATA_W  = SAS_DATA_W_DEF,
  parameter int WORD_W  = SAS_WORD_W_DEF,
  parameter int SCALE_W = SAS_SCALE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_vld,
  input  logic               word_mode,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DATA_W-1:0]  base_in,
  input  logic [DATA_W-1:0]  index_in,
  output logic               res_vld,
  output logic [DATA_W-1:0]  res_out
);
  localparam int SHAMT_W = SCALE_W + 1;

  logic [DATA_W-1:0]  prep_idx;
  logic [DATA_W-1:0]  scaled_idx;
  logic [SHAMT_W-1:0] shamt;
  logic [DATA_W-1:0]  sum_w;
  logic               load_en;

  sas_idx_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep (
    .word_mode (word_mode),
    .index_in  (index_in),
    .prep_idx  (prep_idx)
  );

  sas_scaler #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_scaler (
    .scale     (scale),
    .value_in  (prep_idx),
    .shamt     (shamt),
    .value_out (scaled_idx)
  );

  sas_adder #(.DATA_W(DATA_W)) u_adder (
    .a   (base_in),
    .b   (scaled_idx),
    .sum (sum_w)
  );

  assign load_en = issue_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_out <= '0;
    end else begin
      res_vld <= issue_vld;
      if (load_en) res_out <= sum_w;
    end
  end
endmodule

// File: rtl/sas_unit_chk.sv
module sas_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               issue_vld,
  input logic               word_mode,
  input logic [DATA_W-1:0]  index_in,
  input logic [SCALE_W:0]   shamt,
  input logic [DATA_W-1:0]  prep_idx,
  input logic [DATA_W-1:0]  scaled_idx,
  input logic               res_vld,
  input logic [DATA_W-1:0]  res_out
);
  localparam int MAXSH = 1 << SCALE_W;
  localparam int FIT_W = WORD_W + MAXSH;

  logic prev_rst;
  always_ff @(posedge clk) prev_rst <= rst;

  always_ff @(posedge clk) begin
    if (prev_rst === 1'b1)
      AST_RESET_CLEARS: assert (res_vld == 1'b0 && res_out == '0); // R7
  end

  AST_SHIFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> (shamt != '0 && int'(shamt) <= MAXSH)); // R1

  AST_WORD_UPPER_DROP: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && word_mode) |-> (prep_idx[DATA_W-1:WORD_W] == '0 &&
      prep_idx[WORD_W-1:0] == index_in[WORD_W-1:0])); // R3

  AST_WORD_FITS: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && word_mode) |-> (scaled_idx[DATA_W-1:FIT_W] == '0)); // R4

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    issue_vld |=> res_vld); // R6

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> !res_vld); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> $stable(res_out)); // R8
endmodule

bind sas_unit sas_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .SCALE_W(SCALE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_vld  (issue_vld),
  .word_mode  (word_mode),
  .index_in   (index_in),
  .shamt      (shamt),
  .prep_idx   (prep_idx),
  .scaled_idx (scaled_idx),
  .res_vld    (res_vld),
  .res_out    (res_out)
);

// File: tb/sas_unit_bench.sv
module sas_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_vld;
  logic        word_mode;
  logic [1:0]  scale;
  logic [63:0] base_in;
  logic [63:0] index_in;
  logic        res_vld;
  logic [63:0] res_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sas_unit u_sas_unit (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .word_mode(word_mode),
    .scale(scale), .base_in(base_in), .index_in(index_in),
    .res_vld(res_vld), .res_out(res_out)
  );

  // reference: multiply by a power of two, independent of shifting
  function automatic logic [63:0] ref_model(input logic wm, input logic [1:0] sc,
                                            input logic [63:0] b, input logic [63:0] ix);
    logic [63:0] eff;
    logic [63:0] mul;
    eff = wm ? (ix & 64'h0000_0000_FFFF_FFFF) : ix;
    case (sc)
      2'd0: mul = 64'd2;
      2'd1: mul = 64'd4;
      2'd2: mul = 64'd8;
      default: mul = 64'd16;
    endcase
    return eff * mul + b;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one op at a falling edge, check it at the next falling edge
  task automatic op(input string req, input logic wm, input logic [1:0] sc,
                    input logic [63:0] b, input logic [63:0] ix);
    @(negedge clk);
    issue_vld = 1'b1; word_mode = wm; scale = sc; base_in = b; index_in = ix;
    @(negedge clk);
    issue_vld = 1'b0;
    check1(req, res_vld, 1'b1);
    check64(req, res_out, ref_model(wm, sc, b, ix));
  endtask

  task automatic t_reset();
    rst = 1'b1; issue_vld = 1'b1; word_mode = 1'b0; scale = 2'd3;
    base_in = 64'h1234; index_in = 64'h5678;
    repeat (3) @(negedge clk);
    check1("R7 vld", res_vld, 1'b0);
    check64("R7 out", res_out, 64'd0);
    rst = 1'b0; issue_vld = 1'b0;
  endtask

  task automatic t_scale_sweep();
    for (int s = 0; s < 4; s++) begin
      op("R1", 1'b0, 2'(s), 64'd100, 64'd1);
      check64("R1 literal", res_out, 64'd100 + (64'd1 << (s + 1)));
      op("R2", 1'b0, 2'(s), 64'h0123_4567_89AB_CDEF, 64'h0F0E_0D0C_0B0A_0908);
      op("R3 sweep", 1'b1, 2'(s), 64'h1000_0000_0000_0000, 64'h0000_0000_8765_4321);
    end
  endtask

  task automatic t_all_ones();
    op("R2 ones idx", 1'b0, 2'd3, 64'd0, '1);
    check64("R2 ones literal", res_out, 64'hFFFF_FFFF_FFFF_FFF0);
    op("R4 word ones", 1'b1, 2'd3, 64'd0, '1);
    check64("R4 literal", res_out, 64'h0000_000F_FFFF_FFF0);
    op("R4 word s0", 1'b1, 2'd0, 64'd0, 64'h0000_0000_FFFF_FFFF);
    check64("R4 literal s0", res_out, 64'h0000_0001_FFFF_FFFE);
  endtask

  task automatic t_word_upper();
    op("R3 upper ignored", 1'b1, 2'd1, 64'd7, 64'hDEAD_BEEF_0000_0010);
    check64("R3 literal", res_out, 64'd7 + 64'd64);
    op("R3 upper only", 1'b1, 2'd2, 64'h55, 64'hFFFF_FFFF_0000_0000);
    check64("R3 upper only literal", res_out, 64'h55);
  endtask

  task automatic t_wrap();
    op("R5 wrap", 1'b0, 2'd0, '1, 64'd1);
    check64("R5 literal", res_out, 64'd1);
    op("R5 both ones", 1'b0, 2'd2, '1, '1);
    op("R5 word wrap", 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFF8, 64'd1);
    check64("R5 word literal", res_out, 64'd8);
  endtask

  task automatic t_hold();
    op("R8 setup", 1'b0, 2'd1, 64'd5, 64'd5);
    for (int k = 0; k < 3; k++) begin
      word_mode = 1'(k); scale = 2'(k); base_in = 64'hAAAA + 64'(k); index_in = 64'h9999;
      @(negedge clk);
      check1("R8 vld low", res_vld, 1'b0);
      check64("R8 held", res_out, 64'd25);
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    issue_vld = 1'b1; word_mode = 1'b0; scale = 2'd0; base_in = 64'd1; index_in = 64'd3;
    @(negedge clk);
    check1("R6 first vld", res_vld, 1'b1);
    check64("R6 first", res_out, 64'd7);
    word_mode = 1'b1; scale = 2'd3; base_in = 64'd2; index_in = 64'hF000_0000_0000_0001;
    @(negedge clk);
    check1("R6 second vld", res_vld, 1'b1);
    check64("R6 second", res_out, 64'd18);
    issue_vld = 1'b0;
    @(negedge clk);
    check1("R6 drop", res_vld, 1'b0);
  endtask

  initial begin
    t_reset();
    t_scale_sweep();
    t_all_ones();
    t_word_upper();
    t_wrap();
    t_hold();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule